// File: doc/BRIEF.md
# Program Counter and Stack Sequencer

This block owns the program counter and the stack pointer of a small byte-oriented processor core. A decoder outside the block hands it one control-flow or stack operation at a time: a jump, a call, a return, a register-pair push or a register-pair pop. Each request comes with a 3-bit condition code, a flag to make the operation unconditional, the four status flags, a target address, the address of the following instruction and a 16-bit register-pair value.

Jumps, and calls or returns whose condition fails, finish in a single cycle and never touch memory. A taken call, a taken return, a push and a pop each move one 16-bit word through a byte-wide memory port in two consecutive beats. The stack grows toward lower addresses. The block raises a one-cycle `done` pulse when each operation finishes. After a pop, the value read from the stack appears on `pop_word`.

Top module: `pc_stack_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` becomes 0, `sp` becomes `SP_INIT` (default 0), and `busy` and `done` become 0.
- R2: A condition holds when the flag selected by `cc[2:1]` equals `cc[0]`. The flag positions are `flags[0]` carry, `flags[1]` zero, `flags[2]` sign and `flags[3]` parity. `uncond`=1 makes the condition hold whatever `cc` and `flags` are.
- R3: A request is accepted at a rising edge where `req`=1 and `busy`=0. The operation codes are 0 jump, 1 call, 2 return, 3 push and 4 pop. A jump loads `target` into `pc` if the condition holds and `next_pc` if it does not. For a jump, `done` is high in the cycle after acceptance and no memory strobe is driven.
- R4: A taken call writes `next_pc[15:8]` to address `sp-1` and then `next_pc[7:0]` to address `sp-2`, leaving `sp` two lower. It then loads `target` into `pc`, and `done` is high three cycles after acceptance.
- R5: A taken return reads the low byte at `sp` and then the high byte at `sp+1`, loads the resulting word into `pc` and leaves `sp` two higher. `done` is high three cycles after acceptance.
- R6: A call or return whose condition fails loads `next_pc` into `pc`, leaves `sp` unchanged and drives no memory strobe. Its `done` is high in the cycle after acceptance.
- R7: A push ignores the condition inputs. It writes `pair_in[15:8]` at `sp-1` and then `pair_in[7:0]` at `sp-2`, leaves `sp` two lower, loads `next_pc` into `pc`, and `done` is high three cycles after acceptance.
- R8: A pop reads the low byte at `sp` and then the high byte at `sp+1`, and presents the word on `pop_word` while `done` is high. It leaves `sp` two higher and loads `next_pc` into `pc`.
- R9: A request made while `busy`=1 is ignored and has no effect on `pc`, `sp` or memory. `busy` lasts exactly two cycles for a memory operation, and `done` is high in the cycle after `busy` falls.
- R10: `mem_we` and `mem_re` are never high together, and neither is high while `busy`=0. Each memory beat moves `sp` by exactly one.
- R11: The stack pointer wraps modulo 2^16, so a push from `sp`=0 writes at 0xFFFF and 0xFFFE, and a pop from 0xFFFE returns `sp` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Operation request |
| op | input | 3 | Operation code (0 jump, 1 call, 2 return, 3 push, 4 pop) |
| uncond | input | 1 | 1 = ignore the condition code |
| cc | input | 3 | Condition code: flag select in [2:1], required value in [0] |
| flags | input | 4 | Status flags {parity, sign, zero, carry} |
| target | input | 16 | Jump or call destination |
| next_pc | input | 16 | Address of the following instruction |
| pair_in | input | 16 | Register pair to push |
| mem_addr | output | 16 | Stack memory address |
| mem_we | output | 1 | Stack byte write strobe |
| mem_re | output | 1 | Stack byte read strobe |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read, combinational from `mem_addr` |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Memory operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pop_word | output | 16 | Word taken by the last pop |

## Verification
Single-cycle operations (jumps, push-free not-taken calls and returns) must show their new `pc` and a `done` pulse in the cycle after the accepting edge. Two-beat operations must show them three cycles after that edge. The driver records the cycle number at which it presents each request and stores the due cycle with the expected `pc`, `sp`, popped word and memory-beat count. The monitor samples on the falling edge, checks that every `done` arrives in exactly its due cycle, and then compares the stored values. Stack writes are compared byte by byte, in order, against a queue of expected address and data pairs. Memory beats are counted per operation, which shows that not-taken operations leave memory alone.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  typedef enum logic [2:0] {
    OP_JUMP = 3'd0,
    OP_CALL = 3'd1,
    OP_RET  = 3'd2,
    OP_PUSH = 3'd3,
    OP_POP  = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_HI,
    ST_WR_LO,
    ST_RD_LO,
    ST_RD_HI
  } stk_state_e;

  // flags: [0] carry, [1] zero, [2] sign, [3] parity
  localparam int NUM_FLAGS = 4;

  // cc[2:1] picks the flag, cc[0] is the value it must have
  function automatic logic cond_holds(input logic [2:0] cc,
                                      input logic [NUM_FLAGS-1:0] flags);
    return flags[cc[2:1]] == cc[0];
  endfunction

endpackage

// File: rtl/pcs_cond_unit.sv
module pcs_cond_unit
  import pcs_pkg::*;
(
  input  logic [2:0]           cc,
  input  logic [NUM_FLAGS-1:0] flags,
  input  logic                 uncond,
  output logic                 take
);

  assign take = uncond | cond_holds(cc, flags);

endmodule

// File: rtl/pcs_stack_engine.sv
module pcs_stack_engine
  import pcs_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int SP_INIT = 0,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_wr,
  input  logic              start_rd,
  input  logic [ADDR_W-1:0] wr_word,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] sp,
  output logic              busy,
  output logic              last_beat,
  output logic [ADDR_W-1:0] beat_word
);

  stk_state_e        state_q;
  logic [ADDR_W-1:0] sp_q;
  logic [ADDR_W-1:0] word_q;
  logic [ADDR_W-1:0] sp_below;
  logic [ADDR_W-1:0] sp_above;

  function automatic logic [ADDR_W-1:0] sp_step(input logic [ADDR_W-1:0] v,
                                                input logic down);
    return down ? v - 1'b1 : v + 1'b1;
  endfunction

  assign sp_below = sp_step(sp_q, 1'b1);
  assign sp_above = sp_step(sp_q, 1'b0);

  always_comb begin
    mem_addr  = sp_q;
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_wdata = '0;
    case (state_q)
      ST_WR_HI: begin
        mem_addr  = sp_below;
        mem_we    = 1'b1;
        mem_wdata = word_q[ADDR_W-1:BYTE_W];
      end
      ST_WR_LO: begin
        mem_addr  = sp_below;
        mem_we    = 1'b1;
        mem_wdata = word_q[BYTE_W-1:0];
      end
      ST_RD_LO, ST_RD_HI: begin
        mem_re    = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      sp_q    <= SP_INIT[ADDR_W-1:0];
      word_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_wr) begin
            word_q  <= wr_word;
            state_q <= ST_WR_HI;
          end else if (start_rd) begin
            state_q <= ST_RD_LO;
          end
        end
        ST_WR_HI: begin
          sp_q    <= sp_below;
          state_q <= ST_WR_LO;
        end
        ST_WR_LO: begin
          sp_q    <= sp_below;
          state_q <= ST_IDLE;
        end
        ST_RD_LO: begin
          word_q[BYTE_W-1:0] <= mem_rdata;
          sp_q               <= sp_above;
          state_q            <= ST_RD_HI;
        end
        ST_RD_HI: begin
          sp_q    <= sp_above;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sp        = sp_q;
  assign busy      = (state_q != ST_IDLE);
  assign last_beat = (state_q == ST_WR_LO) || (state_q == ST_RD_HI);
  assign beat_word = {mem_rdata, word_q[BYTE_W-1:0]};

endmodule

// File: rtl/pc_stack_seq.sv
module pc_stack_seq
  import pcs_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int SP_INIT = 0,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req,
  input  logic [2:0]           op,
  input  logic                 uncond,
  input  logic [2:0]           cc,
  input  logic [NUM_FLAGS-1:0] flags,
  input  logic [ADDR_W-1:0]    target,
  input  logic [ADDR_W-1:0]    next_pc,
  input  logic [ADDR_W-1:0]    pair_in,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic                 mem_we,
  output logic                 mem_re,
  output logic [BYTE_W-1:0]    mem_wdata,
  input  logic [BYTE_W-1:0]    mem_rdata,
  output logic [ADDR_W-1:0]    pc,
  output logic [ADDR_W-1:0]    sp,
  output logic                 busy,
  output logic                 done,
  output logic [ADDR_W-1:0]    pop_word
);

  // named internal events
  logic              accept;
  logic              take;
  logic              is_jump;
  logic              flow_mem;   // taken call or return
  logic              start_wr;
  logic              start_rd;
  logic              last_beat;
  logic [ADDR_W-1:0] beat_word;
  logic [ADDR_W-1:0] wr_word;

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pop_q;
  logic [ADDR_W-1:0] target_q;
  logic              done_q;
  op_e               op_q;

  pcs_cond_unit u_cond (
    .cc     (cc),
    .flags  (flags),
    .uncond (uncond),
    .take   (take)
  );

  assign accept   = req && !busy;
  assign is_jump  = (op == OP_JUMP);
  assign flow_mem = take && ((op == OP_CALL) || (op == OP_RET));
  assign start_wr = accept && ((take && (op == OP_CALL)) || (op == OP_PUSH));
  assign start_rd = accept && ((take && (op == OP_RET)) || (op == OP_POP));
  assign wr_word  = (op == OP_CALL) ? next_pc : pair_in;

  pcs_stack_engine #(
    .BYTE_W  (BYTE_W),
    .SP_INIT (SP_INIT)
  ) u_stack (
    .clk       (clk),
    .rst       (rst),
    .start_wr  (start_wr),
    .start_rd  (start_rd),
    .wr_word   (wr_word),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata),
    .sp        (sp),
    .busy      (busy),
    .last_beat (last_beat),
    .beat_word (beat_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= '0;
      pop_q    <= '0;
      target_q <= '0;
      done_q   <= 1'b0;
      op_q     <= OP_JUMP;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        op_q     <= op_e'(op);
        target_q <= target;
        if (!flow_mem) begin
          pc_q <= (is_jump && take) ? target : next_pc;
        end
        if (!(start_wr || start_rd)) begin
          done_q <= 1'b1;
        end
      end
      if (last_beat) begin
        done_q <= 1'b1;
        case (op_q)
          OP_CALL: pc_q  <= target_q;
          OP_RET:  pc_q  <= beat_word;
          OP_POP:  pop_q <= beat_word;
          default: ;
        endcase
      end
    end
  end

  assign pc       = pc_q;
  assign done     = done_q;
  assign pop_word = pop_q;

endmodule

// File: rtl/pcs_seq_checker.sv
module pcs_seq_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         busy,
  input logic         done,
  input logic         mem_we,
  input logic         mem_re,
  input logic [W-1:0] sp,
  input logic [W-1:0] pc
);

  // R10: write and read strobes are exclusive
  a_r10_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  // R10: no memory traffic while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_we && !mem_re));

  // R4 / R7: each write beat lowers sp by one
  a_r4_write_step: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (sp == $past(sp) - 1'b1));

  // R5 / R8: each read beat raises sp by one
  a_r5_read_step: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> (sp == $past(sp) + 1'b1));

  // R6: sp moves only on memory beats
  a_r6_sp_quiet: assert property (@(posedge clk) disable iff (rst)
    !(mem_we || mem_re) |=> $stable(sp));

  // R9: a memory operation keeps busy for exactly two cycles
  a_r9_busy_two: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |=> !busy);

  // R9: completion accompanies the end of busy
  a_r9_done_at_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R4 / R5: pc holds between the two beats
  a_r4_pc_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy || $stable(pc)));

endmodule

bind pc_stack_seq pcs_seq_checker #(.W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .busy   (busy),
  .done   (done),
  .mem_we (mem_we),
  .mem_re (mem_re),
  .sp     (sp),
  .pc     (pc)
);

// File: tb/sim_pc_stack_seq.sv
`timescale 1ns/1ps
module sim_pc_stack_seq;
  import pcs_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        uncond = 1'b0;
  logic [2:0]  cc = 3'd0;
  logic [3:0]  flags = 4'd0;
  logic [15:0] target = '0;
  logic [15:0] next_pc = '0;
  logic [15:0] pair_in = '0;
  logic [15:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [15:0] pc, sp, pop_word;
  logic        busy, done;

  always #2 clk = ~clk;   // 250 MHz

  pc_stack_seq u0 (
    .clk(clk), .rst(rst), .req(req), .op(op), .uncond(uncond), .cc(cc),
    .flags(flags), .target(target), .next_pc(next_pc), .pair_in(pair_in),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc(pc), .sp(sp),
    .busy(busy), .done(done), .pop_word(pop_word)
  );

  // environment memory: stack traffic stays inside one 256-byte window
  logic [7:0] env_mem [0:255];
  assign mem_rdata = env_mem[mem_addr[7:0]];

  typedef struct {
    logic [15:0] pc;
    logic [15:0] sp;
    logic [15:0] pop;
    bit          chk_pop;
    int          due;
    int          beats;
    string       tag;
  } exp_t;

  exp_t        eq[$];
  logic [23:0] wq[$];
  int checks = 0, fails = 0, cyc = 0, beats_seen = 0;
  bit finished = 0;

  logic [15:0] m_pc = '0, m_sp = '0;
  logic [7:0]  m_mem [0:255];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && (mem_we || mem_re)) beats_seen <= beats_seen + 1;
    if (!rst && mem_we) begin
      env_mem[mem_addr[7:0]] <= mem_wdata;
      if (wq.size() == 0)
        chk(0, "R4", "unexpected write", {8'h0, mem_addr, mem_wdata}, 32'h0);
      else begin
        logic [23:0] w;
        w = wq.pop_front();
        chk({mem_addr, mem_wdata} == w, "R4/R7", "write addr_data",
            {8'h0, mem_addr, mem_wdata}, {8'h0, w});
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      if (eq.size() == 0) chk(0, "R3", "unexpected done", 32'h1, 32'h0);
      else begin
        exp_t it;
        it = eq.pop_front();
        chk(cyc == it.due, it.tag, "done cycle", cyc, it.due);
        chk(pc == it.pc, it.tag, "pc", pc, it.pc);
        chk(sp == it.sp, it.tag, "sp", sp, it.sp);
        chk(beats_seen == it.beats, it.tag, "memory beats", beats_seen, it.beats);
        if (it.chk_pop) chk(pop_word == it.pop, it.tag, "pop_word", pop_word, it.pop);
      end
      beats_seen <= 0;
    end
  end

  function automatic bit model_cond(input logic [2:0] c, input logic [3:0] f);
    case (c)
      3'd0: return !f[0];
      3'd1: return  f[0];
      3'd2: return !f[1];
      3'd3: return  f[1];
      3'd4: return !f[2];
      3'd5: return  f[2];
      3'd6: return !f[3];
      default: return f[3];
    endcase
  endfunction

  task automatic model_push(input logic [15:0] w);
    m_sp = m_sp - 16'd1;
    m_mem[m_sp[7:0]] = w[15:8];
    wq.push_back({m_sp, w[15:8]});
    m_sp = m_sp - 16'd1;
    m_mem[m_sp[7:0]] = w[7:0];
    wq.push_back({m_sp, w[7:0]});
  endtask

  task automatic model_pop(output logic [15:0] w);
    w[7:0]  = m_mem[m_sp[7:0]];
    m_sp = m_sp + 16'd1;
    w[15:8] = m_mem[m_sp[7:0]];
    m_sp = m_sp + 16'd1;
  endtask

  // driver: called at a falling edge with busy low
  task automatic present(input logic [2:0] o, input bit u, input logic [2:0] c,
                         input logic [3:0] f, input logic [15:0] tgt,
                         input logic [15:0] nxt, input logic [15:0] pr,
                         input string tag);
    exp_t it;
    bit t;
    logic [15:0] w;
    t = u || model_cond(c, f);
    it.chk_pop = 0; it.pop = '0; it.beats = 0; it.tag = tag;
    case (o)
      OP_JUMP: m_pc = t ? tgt : nxt;
      OP_CALL: if (t) begin model_push(nxt); m_pc = tgt; it.beats = 2; end
               else m_pc = nxt;
      OP_RET:  if (t) begin model_pop(w); m_pc = w; it.beats = 2; end
               else m_pc = nxt;
      OP_PUSH: begin model_push(pr); m_pc = nxt; it.beats = 2; end
      default: begin model_pop(w); it.pop = w; it.chk_pop = 1;
                     m_pc = nxt; it.beats = 2; end
    endcase
    it.pc = m_pc; it.sp = m_sp;
    it.due = cyc + ((it.beats != 0) ? 3 : 1);
    op = o; uncond = u; cc = c; flags = f; target = tgt; next_pc = nxt;
    pair_in = pr; req = 1'b1;
    eq.push_back(it);
  endtask

  task automatic settle();
    while (eq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_op(input logic [2:0] o, input bit u, input logic [2:0] c,
                        input logic [3:0] f, input logic [15:0] tgt,
                        input logic [15:0] nxt, input logic [15:0] pr,
                        input string tag);
    present(o, u, c, f, tgt, nxt, pr, tag);
    @(negedge clk);
    req = 1'b0;
    settle();
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin env_mem[i] = 8'h00; m_mem[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(pc == 16'h0, "R1", "pc after reset", pc, 0);
    chk(sp == 16'h0, "R1", "sp after reset", sp, 0);
    chk(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);

    // R3: unconditional jump
    run_op(OP_JUMP, 1, 3'd0, 4'b0001, 16'h1234, 16'h0011, 16'h0, "R3");

    // R2, R3: every condition against two complementary flag sets
    for (int c = 0; c < 8; c++)
      run_op(OP_JUMP, 0, c[2:0], 4'b0101, 16'h1000 + 16'(c), 16'h0100 + 16'(c), 16'h0, "R2");
    for (int c = 0; c < 8; c++)
      run_op(OP_JUMP, 0, c[2:0], 4'b1010, 16'h2000 + 16'(c), 16'h0200 + 16'(c), 16'h0, "R2");

    // R7, R11: push from sp=0 wraps to 0xFFFF/0xFFFE; condition ignored
    run_op(OP_PUSH, 0, 3'd1, 4'b0000, 16'h7777, 16'h0301, 16'hABCD, "R7_R11");

    // R4: taken call on carry set
    run_op(OP_CALL, 0, 3'd1, 4'b0001, 16'h4000, 16'h2003, 16'h0, "R4");

    // R6: not-taken call (zero set required, zero clear) and not-taken return
    run_op(OP_CALL, 0, 3'd3, 4'b0000, 16'h5000, 16'h4003, 16'h0, "R6");
    run_op(OP_RET,  0, 3'd7, 4'b0000, 16'h0000, 16'h4004, 16'h0, "R6");

    // R5: taken return on parity clear
    run_op(OP_RET, 0, 3'd6, 4'b0000, 16'h0000, 16'h4005, 16'h0, "R5");

    // R8, R11: pop back to sp=0
    run_op(OP_POP, 1, 3'd0, 4'b0000, 16'h0, 16'h2004, 16'h0, "R8_R11");

    // R9: request presented while busy is ignored
    present(OP_CALL, 1, 3'd0, 4'b0000, 16'h6000, 16'h2005, 16'h0, "R9");
    @(negedge clk);
    chk(busy == 1'b1, "R9", "busy during call", busy, 1);
    op = OP_JUMP; target = 16'hDEAD; uncond = 1'b1;
    @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    settle();
    chk(pc == 16'h6000, "R9", "pc after ignored request", pc, 16'h6000);

    // R5: return from that call
    run_op(OP_RET, 1, 3'd0, 4'b0000, 16'h0, 16'h6001, 16'h0, "R5");

    // R7, R8: push then pop a second pattern
    run_op(OP_PUSH, 1, 3'd0, 4'b0000, 16'h0, 16'h2006, 16'h5AC3, "R7");
    run_op(OP_POP,  0, 3'd2, 4'b1111, 16'h0, 16'h2007, 16'h0, "R8");

    chk(wq.size() == 0, "R4/R7", "pending writes", wq.size(), 0);
    chk(eq.size() == 0, "R3", "pending completions", eq.size(), 0);
    summary();
  end

endmodule